// File: doc/BRIEF.md
# Condition Code Register and Branch Decision Unit

This block holds the four condition-code bits of the processor status word and decides conditional branches. Each time the execute stage finishes an arithmetic operation, it presents the 32-bit result and its overflow flag. The block then records whether the result was zero, negative or positive, and whether it overflowed. For a compare, it takes the two operands, compares them as signed numbers and records equal, less or greater. Compare results use the same three bit positions as the arithmetic zero, negative and positive flags.

For a branch, the instruction decoder slices the four-bit mask field out of the branch word and presents it here. That field is instruction bits 25..22, and bit 25 lines up with condition bit 3. The block raises its taken flag in the same cycle if any mask bit meets a set condition bit. The decision uses the code as it stood before the branch. Result generation and program-counter update live elsewhere.

Operations arrive as a single strobe, `op_valid`, with the operation class beside it. The unit accepts a strobe in every cycle and never applies back-pressure, so it has no ready output. Upstream may present one operation per clock.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset `cc_out` is 4'b0000, and `br_taken` is 0 while no branch is presented.
- R2: An arithmetic strobe (`op_valid`=1, `op_cls`=2'b01) loads the code on the next clock edge. A zero result gives bit 3, a negative result (bit 31 set) gives bit 2 and a positive result gives bit 1. Exactly one of these three bits is set and the others are cleared.
- R3: On an arithmetic strobe, `cc_out[0]` takes the value of `arith_ovf`, independently of the sign bits.
- R4: A compare strobe (`op_cls`=2'b10) compares `cmp_a` with `cmp_b` as signed 32-bit values. Equal gives bit 3, a less than b gives bit 2 and a greater than b gives bit 1. Bit 0 and the other two flag bits are cleared.
- R5: The code keeps its value when `op_valid` is 0, or when the class is none (2'b00) or branch (2'b11), whatever the data inputs carry.
- R6: `br_taken` is 1 in the same cycle exactly when `op_valid`=1, `op_cls`=2'b11 and `br_mask & cc_out` is nonzero, with `br_mask[i]` aligned to `cc_out[i]`. Examples: code 0010 with mask 1010 is taken, code 0100 with mask 0110 is taken, code 1000 with mask 1111 is taken, and mask 0000 is never taken.
- R7: A branch decision uses the code from before the branch, and the branch itself leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe, accepted every cycle |
| op_cls | input | 2 | 00 none, 01 arithmetic, 10 compare, 11 branch |
| arith_res | input | 32 | Arithmetic result |
| arith_ovf | input | 1 | Arithmetic overflow flag |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_mask | input | 4 | Branch mask, bit 3 aligned to condition bit 3 |
| cc_out | output | 4 | Condition code, bit 3 is status-word bit 31 |
| br_taken | output | 1 | Branch taken decision |

## Verification
The code register is due one clock edge after an arithmetic or compare strobe. The taken flag is combinational and is due in the same cycle as the branch strobe. The bench changes inputs on the falling edge and checks `cc_out` on the falling edge after the rising edge that loads it. It checks `br_taken` one nanosecond after driving the branch, before that cycle's rising edge. It then checks `cc_out` again one cycle later to confirm the branch left the code alone.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_W = 4;
  localparam int CC_EQ  = 3;
  localparam int CC_LT  = 2;
  localparam int CC_GT  = 1;
  localparam int CC_OVF = 0;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_ARITH  = 2'b01,
    OP_CMP    = 2'b10,
    OP_BRANCH = 2'b11
  } op_cls_e;
endpackage

// File: rtl/cc_arith_flags.sv
module cc_arith_flags
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              ovf,
  output logic [CC_W-1:0]   flags
);
  logic is_zero, is_neg, is_pos;

  always_comb begin
    is_zero = (res == '0);
    is_neg  = res[DATA_W-1];
    is_pos  = !is_zero && !is_neg;
    flags          = '0;
    flags[CC_EQ]   = is_zero;
    flags[CC_LT]   = is_neg;
    flags[CC_GT]   = is_pos;
    flags[CC_OVF]  = ovf;
  end
endmodule

// File: rtl/cc_cmp_flags.sv
module cc_cmp_flags
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit SIGNED = 1'b1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [CC_W-1:0]   flags
);
  logic eq, lt;

  generate
    if (SIGNED) begin : g_signed
      assign lt = ($signed(a) < $signed(b));
    end else begin : g_unsigned
      assign lt = (a < b);
    end
  endgenerate

  assign eq = (a == b);

  always_comb begin
    flags         = '0;
    flags[CC_EQ]  = eq;
    flags[CC_LT]  = lt;
    flags[CC_GT]  = !eq && !lt;
    flags[CC_OVF] = 1'b0;
  end
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
  import cc_pkg::*;
(
  input  logic            en,
  input  logic [CC_W-1:0] cc,
  input  logic [CC_W-1:0] mask,
  output logic            taken
);
  logic [CC_W-1:0] hit;

  generate
    for (genvar i = 0; i < CC_W; i++) begin : g_hit
      assign hit[i] = cc[i] & mask[i];
    end
  endgenerate

  assign taken = en & (|hit);
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit CMP_SIGNED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_cls,
  input  logic [DATA_W-1:0] arith_res,
  input  logic              arith_ovf,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [CC_W-1:0]   br_mask,
  output logic [CC_W-1:0]   cc_out,
  output logic              br_taken
);
  logic [CC_W-1:0] arith_flags, cmp_flags, cc_q, cc_d;
  logic            is_branch;

  cc_arith_flags #(.DATA_W(DATA_W)) u_arith (
    .res(arith_res), .ovf(arith_ovf), .flags(arith_flags)
  );

  cc_cmp_flags #(.DATA_W(DATA_W), .SIGNED(CMP_SIGNED)) u_cmp (
    .a(cmp_a), .b(cmp_b), .flags(cmp_flags)
  );

  always_comb begin
    cc_d = cc_q;
    if (op_valid) begin
      unique case (op_cls)
        OP_ARITH: cc_d = arith_flags;
        OP_CMP:   cc_d = cmp_flags;
        default:  cc_d = cc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cc_q <= '0;
    else        cc_q <= cc_d;
  end

  assign is_branch = op_valid && (op_cls == OP_BRANCH);

  cc_branch_eval u_br (
    .en(is_branch), .cc(cc_q), .mask(br_mask), .taken(br_taken)
  );

  assign cc_out = cc_q;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_cls,
  input logic [DATA_W-1:0] arith_res,
  input logic              arith_ovf,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic [CC_W-1:0]   br_mask,
  input logic [CC_W-1:0]   cc_out,
  input logic              br_taken
);
  a_r2_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_cls == 2'b01 && arith_res == '0 && !arith_ovf) |=> (cc_out == 4'b1000));

  a_r2_one_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_cls == 2'b01) |=> ($countones(cc_out[3:1]) == 1));

  a_r3_ovf_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_cls == 2'b01) |=> (cc_out[0] == $past(arith_ovf)));

  a_r4_cmp_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_cls == 2'b10) |=> (!cc_out[0] && $onehot0(cc_out[3:1])
                                       && (cc_out[3] == ($past(cmp_a) == $past(cmp_b)))));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_cls == 2'b00 || op_cls == 2'b11) |=> $stable(cc_out));

  a_r6_taken_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (op_valid && op_cls == 2'b11 && br_mask != '0));

  a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (br_mask == '0) |-> !br_taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls),
  .arith_res(arith_res), .arith_ovf(arith_ovf), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .br_mask(br_mask), .cc_out(cc_out), .br_taken(br_taken)
);

// File: tb/tb_cc_branch_unit.sv
`timescale 1ns/1ps
module tb_cc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_cls;
  logic [31:0] arith_res;
  logic        arith_ovf;
  logic [31:0] cmp_a, cmp_b;
  logic [3:0]  br_mask;
  logic [3:0]  cc_out;
  logic        br_taken;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cc_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls),
    .arith_res(arith_res), .arith_ovf(arith_ovf), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_mask(br_mask), .cc_out(cc_out), .br_taken(br_taken)
  );

  logic [31:0] vals [8];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_arith(input logic [31:0] r, input logic o);
    if (r == 0)      return {3'b100, o};
    else if (r[31])  return {3'b010, o};
    else             return {3'b001, o};
  endfunction

  function automatic logic [3:0] exp_cmp(input logic [31:0] a, input logic [31:0] b);
    if (a == b)                     return 4'b1000;
    else if ($signed(a) < $signed(b)) return 4'b0100;
    else                            return 4'b0010;
  endfunction

  task automatic idle();
    op_valid = 1'b0; op_cls = 2'b00; arith_res = '0; arith_ovf = 1'b0;
    cmp_a = '0; cmp_b = '0; br_mask = '0;
  endtask

  // drive at negedge, rising edge loads, check at next negedge
  task automatic do_arith(input logic [31:0] r, input logic o);
    @(negedge clk);
    op_valid = 1'b1; op_cls = 2'b01; arith_res = r; arith_ovf = o;
    @(negedge clk);
    idle();
  endtask

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_cls = 2'b10; cmp_a = a; cmp_b = b;
    @(negedge clk);
    idle();
  endtask

  task automatic do_branch(input logic v, input logic [3:0] m, input logic [3:0] cc_now);
    @(negedge clk);
    op_valid = v; op_cls = 2'b11; br_mask = m;
    arith_res = 32'hFFFF_FFFF; cmp_a = 32'h1; cmp_b = 32'h2;
    #1;
    check("R6 taken", {31'b0, br_taken}, {31'b0, v && ((m & cc_now) != 0)});
    @(negedge clk);
    idle();
    check("R7 cc kept by branch", {28'b0, cc_out}, {28'b0, cc_now});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'd5;
    vals[6] = 32'hFFFF_FFFB; vals[7] = 32'd2;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cc reset", {28'b0, cc_out}, 32'h0);
    check("R1 taken reset", {31'b0, br_taken}, 32'h0);

    // R2 / R3 arithmetic sweep
    for (int i = 0; i < 8; i++) begin
      for (int o = 0; o < 2; o++) begin
        do_arith(vals[i], o[0]);
        check("R2 R3 arith cc", {28'b0, cc_out}, {28'b0, exp_arith(vals[i], o[0])});
      end
    end

    // R4 compare sweep over all pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        do_cmp(vals[i], vals[j]);
        check("R4 compare cc", {28'b0, cc_out}, {28'b0, exp_cmp(vals[i], vals[j])});
      end
    end

    // R5 hold cases: set a known code, then apply non-updating stimulus
    do_arith(32'hFFFF_FFF0, 1'b1); // 0101
    @(negedge clk);
    op_valid = 1'b0; op_cls = 2'b01; arith_res = 32'h0;
    @(negedge clk);
    check("R5 hold valid low arith", {28'b0, cc_out}, 32'h5);
    op_valid = 1'b0; op_cls = 2'b10; cmp_a = 32'h3; cmp_b = 32'h3;
    @(negedge clk);
    check("R5 hold valid low cmp", {28'b0, cc_out}, 32'h5);
    op_valid = 1'b1; op_cls = 2'b00; arith_res = 32'h0; cmp_a = 32'h9; cmp_b = 32'h1;
    @(negedge clk);
    check("R5 hold class none", {28'b0, cc_out}, 32'h5);
    idle();

    // R6 / R7 branch sweep over reachable codes and all masks
    for (int c = 0; c < 7; c++) begin
      logic [3:0] cc_now;
      case (c)
        0: begin do_arith(32'h0, 1'b0);        cc_now = 4'b1000; end
        1: begin do_arith(32'h8000_0000, 1'b0); cc_now = 4'b0100; end
        2: begin do_arith(32'h10, 1'b0);       cc_now = 4'b0010; end
        3: begin do_arith(32'h0, 1'b1);        cc_now = 4'b1001; end
        4: begin do_arith(32'hF000_0000, 1'b1); cc_now = 4'b0101; end
        5: begin do_cmp(32'd7, 32'd3);          cc_now = 4'b0010; end
        default: begin do_cmp(32'hFFFF_FFFF, 32'd3); cc_now = 4'b0100; end
      endcase
      check("R2 R4 setup cc", {28'b0, cc_out}, {28'b0, cc_now});
      for (int m = 0; m < 16; m++) begin
        do_branch(1'b1, m[3:0], cc_now);
        do_branch(1'b0, m[3:0], cc_now);
      end
    end

    // R6 listed examples
    do_arith(32'h22, 1'b0);          do_branch(1'b1, 4'b1010, 4'b0010);
    do_cmp(32'd1, 32'd9);            do_branch(1'b1, 4'b0110, 4'b0100);
    do_cmp(32'd4, 32'd4);            do_branch(1'b1, 4'b1111, 4'b1000);

    finish_run();
  end
endmodule